// File: doc/BRIEF.md
# UTOPIA Level 2 PHY-Side Cell Source

This block is the physical-layer end of the cell path towards an ATM-layer master on a shared UTOPIA Level 2 bus. Cells of 53 bytes arrive one byte at a time over an internal valid/ready stream and are kept in a small ring of cell slots. The master controls the transfer with an active-low enable and a 5-bit address. It polls the address lines to learn whether this device has a cell. It then selects the device and reads the cell byte by byte, with start-of-cell marking the first byte.

Several PHYs share the bus, so each output comes with an enable. Data and start-of-cell are driven only in the cycle after a selected enable cycle. Cell-available is driven only in the cycle after a poll of this device's address. The three-state buffers themselves sit in the pad ring. When an enable is low, its outputs are forced to zero. Everything runs on one clock.

The write stream applies back-pressure. `wr_ready` is high while at least one slot is free. A byte is taken on each clock edge where `wr_valid` and `wr_ready` are both high. When every slot holds a cell, `wr_ready` drops and the source must hold its byte until a slot frees.

Top module: `utx_l2_src`

## Requirements
- R1: During and right after reset, `wr_ready` is 1, and `rx_bus_oe`, `rx_clav_oe`, `rx_soc`, `rx_clav` and `rx_data` are all 0.
- R2: `rx_soc` is 1 only while the bus carries byte 0 of a cell. The bytes of a cell reach the bus in the order they were written, with bit 7 as the MSB.
- R3: Each clock cycle in which `rx_enb_n` is 0 while the device is selected puts exactly one byte on the bus in the following cycle.
- R4: `rx_bus_oe` is 1 only in a cycle that follows a cycle with `rx_enb_n` at 0 while the device was selected. In all other cycles `rx_data` and `rx_soc` are 0.
- R5: `rx_clav_oe` is 1 exactly in the cycle after `rx_addr` equals `MY_ADDR`, whatever the state of `rx_enb_n`.
- R6: When polled, `rx_clav` is 1 if, in the poll cycle, at least one fully written cell had not yet started its transfer. Otherwise it is 0.
- R7: Selection is taken from `rx_addr` on each cycle with `rx_enb_n` at 1 and is held while `rx_enb_n` is 0. An unselected device keeps `rx_bus_oe` at 0.
- R8: Raising `rx_enb_n` in the middle of a cell pauses the transfer. When the enable falls again, the transfer resumes at the next byte, with none lost or repeated.
- R9: A byte is accepted on a clock edge where `wr_valid` and `wr_ready` are both 1. Every 53 accepted bytes form one cell. A cell is not reported by `rx_clav` until its 53rd byte is accepted.
- R10: `wr_ready` is 0 while all `NCELLS` slots hold cells, and bytes offered then are ignored. A slot frees, and `wr_ready` returns, on the edge that moves byte 52 of a cell onto the bus.
- R11: A selected device with no cell stored answers an enable cycle with `rx_bus_oe` at 1, `rx_data` at 0 and `rx_soc` at 0, and consumes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change after its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Write stream ready; low when all slots are full |
| wr_data | input | 8 | Write stream byte |
| rx_enb_n | input | 1 | Active-low transfer enable from the master |
| rx_addr | input | 5 | Poll and select address from the master |
| rx_data | output | 8 | Cell byte to the master, zero when not enabled |
| rx_soc | output | 1 | Start of cell, high with byte 0 |
| rx_bus_oe | output | 1 | Enable for the pad drivers of data and start-of-cell |
| rx_clav | output | 1 | Cell available, zero when not enabled |
| rx_clav_oe | output | 1 | Enable for the pad driver of cell-available |

## Verification
Every bus and poll result is due exactly one clock after the cycle that caused it. An enable or address applied in cycle N shows up in the enables, data, start-of-cell and cell-available of cycle N+1. A written byte counts toward `rx_clav` only in polls made after the edge that accepted it. Slot release shows on `wr_ready` in the same cycle that byte 52 appears on the bus. The bench drives inputs on the falling edge and checks each result on the next falling edge. The stimulus applied at a falling edge is therefore always compared one full cycle later, and each result is read half a cycle after the edge that produced it.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int unsigned CELL_BYTES = 53;
  localparam int unsigned IDX_W      = $clog2(CELL_BYTES);
  typedef logic [IDX_W-1:0] idx_t;
  localparam idx_t LAST_IDX = idx_t'(CELL_BYTES - 1);
endpackage

// File: rtl/utx_cell_store.sv
module utx_cell_store
  import utx_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned NCELLS = 2,
  parameter int unsigned CNT_W  = $clog2(NCELLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [DW-1:0]    wr_data,
  input  idx_t             rd_idx,
  input  logic             rd_done,
  output logic [DW-1:0]    rd_data,
  output logic [CNT_W-1:0] filled
);
  localparam int unsigned SLOT_W = (NCELLS > 1) ? $clog2(NCELLS) : 1;
  localparam int unsigned DEPTH  = NCELLS * CELL_BYTES;
  localparam int unsigned ADDR_W = $clog2(DEPTH);

  logic [DW-1:0]     mem [DEPTH];
  logic [SLOT_W-1:0] wslot_q, rslot_q;
  idx_t              widx_q;
  logic [CNT_W-1:0]  filled_q;
  logic              wr_fire, commit;
  logic [ADDR_W-1:0] waddr, raddr;

  function automatic logic [SLOT_W-1:0] slot_inc(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(NCELLS - 1)) ? '0 : s + SLOT_W'(1);
  endfunction

  assign wr_ready = (filled_q < CNT_W'(NCELLS));
  assign wr_fire  = wr_valid && wr_ready;
  assign commit   = wr_fire && (widx_q == LAST_IDX);
  assign waddr    = ADDR_W'(wslot_q) * ADDR_W'(CELL_BYTES) + ADDR_W'(widx_q);
  assign raddr    = ADDR_W'(rslot_q) * ADDR_W'(CELL_BYTES) + ADDR_W'(rd_idx);
  assign rd_data  = mem[raddr];
  assign filled   = filled_q;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[waddr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wslot_q  <= '0;
      rslot_q  <= '0;
      widx_q   <= '0;
      filled_q <= '0;
    end else begin
      if (wr_fire) begin
        widx_q <= commit ? '0 : widx_q + idx_t'(1);
        if (commit) wslot_q <= slot_inc(wslot_q);
      end
      if (rd_done) rslot_q <= slot_inc(rslot_q);
      filled_q <= filled_q + CNT_W'(commit) - CNT_W'(rd_done);
    end
  end
endmodule

// File: rtl/utx_bus_ctl.sv
module utx_bus_ctl
  import utx_pkg::*;
#(
  parameter int unsigned    DW      = 8,
  parameter int unsigned    AW      = 5,
  parameter logic [AW-1:0]  MY_ADDR = 5'd3,
  parameter int unsigned    CNT_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enb_n,
  input  logic [AW-1:0]    addr,
  input  logic [CNT_W-1:0] filled,
  input  logic [DW-1:0]    rd_data,
  output idx_t             rd_idx,
  output logic             rd_done,
  output logic             cells_waiting,
  output logic             bus_oe,
  output logic [DW-1:0]    bus_data,
  output logic             bus_soc
);
  logic          sel_q, drv_q, soc_q;
  logic [DW-1:0] dat_q;
  idx_t          idx_q;
  logic          go, take, in_prog;

  assign go      = !enb_n && sel_q;
  assign take    = go && (filled != '0);
  assign rd_done = take && (idx_q == LAST_IDX);
  assign rd_idx  = idx_q;
  assign in_prog = (idx_q != '0);
  assign cells_waiting = in_prog ? (filled > CNT_W'(1)) : (filled != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      drv_q <= 1'b0;
      soc_q <= 1'b0;
      dat_q <= '0;
      idx_q <= '0;
    end else begin
      if (enb_n) sel_q <= (addr == MY_ADDR);
      drv_q <= go;
      if (take) begin
        dat_q <= rd_data;
        soc_q <= (idx_q == '0);
        idx_q <= rd_done ? '0 : idx_q + idx_t'(1);
      end else if (go) begin
        dat_q <= '0;
        soc_q <= 1'b0;
      end
    end
  end

  assign bus_oe   = drv_q;
  assign bus_data = drv_q ? dat_q : '0;
  assign bus_soc  = drv_q && soc_q;
endmodule

// File: rtl/utx_poll_resp.sv
module utx_poll_resp #(
  parameter int unsigned   AW      = 5,
  parameter logic [AW-1:0] MY_ADDR = 5'd3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          cells_waiting,
  output logic          clav_oe,
  output logic          clav
);
  logic poll_q, clav_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      poll_q <= 1'b0;
      clav_q <= 1'b0;
    end else begin
      poll_q <= (addr == MY_ADDR);
      clav_q <= cells_waiting;
    end
  end

  assign clav_oe = poll_q;
  assign clav    = poll_q && clav_q;
endmodule

// File: rtl/utx_l2_src.sv
module utx_l2_src
  import utx_pkg::*;
#(
  parameter int unsigned   DW      = 8,
  parameter int unsigned   AW      = 5,
  parameter int unsigned   NCELLS  = 2,
  parameter logic [AW-1:0] MY_ADDR = 5'd3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          rx_enb_n,
  input  logic [AW-1:0] rx_addr,
  output logic [DW-1:0] rx_data,
  output logic          rx_soc,
  output logic          rx_bus_oe,
  output logic          rx_clav,
  output logic          rx_clav_oe
);
  localparam int unsigned CNT_W = $clog2(NCELLS + 1);

  idx_t             rd_idx;
  logic             rd_done;
  logic [DW-1:0]    rd_data;
  logic [CNT_W-1:0] filled;
  logic             cells_waiting;

  utx_cell_store #(.DW(DW), .NCELLS(NCELLS), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_done(rd_done), .rd_data(rd_data), .filled(filled)
  );

  utx_bus_ctl #(.DW(DW), .AW(AW), .MY_ADDR(MY_ADDR), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .enb_n(rx_enb_n), .addr(rx_addr),
    .filled(filled), .rd_data(rd_data), .rd_idx(rd_idx), .rd_done(rd_done),
    .cells_waiting(cells_waiting),
    .bus_oe(rx_bus_oe), .bus_data(rx_data), .bus_soc(rx_soc)
  );

  utx_poll_resp #(.AW(AW), .MY_ADDR(MY_ADDR)) u_poll (
    .clk(clk), .rst_n(rst_n), .addr(rx_addr), .cells_waiting(cells_waiting),
    .clav_oe(rx_clav_oe), .clav(rx_clav)
  );
endmodule

// File: rtl/utx_l2_src_chk.sv
module utx_l2_src_chk #(
  parameter int unsigned   AW      = 5,
  parameter int unsigned   NCELLS  = 2,
  parameter logic [AW-1:0] MY_ADDR = 5'd3,
  parameter int unsigned   CNT_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_enb_n,
  input logic [AW-1:0]    rx_addr,
  input logic             rx_bus_oe,
  input logic             rx_soc,
  input logic             rx_clav_oe,
  input logic             rx_clav,
  input logic [CNT_W-1:0] filled
);
  AST_BUS_AFTER_ENB: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bus_oe |-> $past(!rx_enb_n)); // R4
  AST_CLAV_AFTER_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clav_oe |-> ($past(rx_addr) == MY_ADDR)); // R5
  AST_SOC_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_soc |-> rx_bus_oe); // R2
  AST_SOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_soc |=> !rx_soc); // R2
  AST_CLAV_HAS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clav_oe && rx_clav) |-> ($past(filled) != '0)); // R6
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    filled <= CNT_W'(NCELLS)); // R10
endmodule

bind utx_l2_src utx_l2_src_chk #(.AW(AW), .NCELLS(NCELLS), .MY_ADDR(MY_ADDR), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_enb_n(rx_enb_n), .rx_addr(rx_addr),
  .rx_bus_oe(rx_bus_oe), .rx_soc(rx_soc), .rx_clav_oe(rx_clav_oe),
  .rx_clav(rx_clav), .filled(filled)
);

// File: tb/utx_l2_src_test.sv
module utx_l2_src_test;
  localparam logic [4:0] MY = 5'd3;

  logic       clk = 1'b0;
  logic       rst_n, wr_valid, wr_ready, rx_enb_n;
  logic [7:0] wr_data, rx_data;
  logic [4:0] rx_addr;
  logic       rx_soc, rx_bus_oe, rx_clav, rx_clav_oe;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  utx_l2_src #(.NCELLS(2), .MY_ADDR(MY)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rx_enb_n(rx_enb_n), .rx_addr(rx_addr),
    .rx_data(rx_data), .rx_soc(rx_soc), .rx_bus_oe(rx_bus_oe),
    .rx_clav(rx_clav), .rx_clav_oe(rx_clav_oe)
  );

  // vector: {enb_n, addr[4:0], exp_bus_oe, exp_clav_oe, exp_clav}
  localparam logic [8:0] VEC [8] = '{
    {1'b1, 5'd3,  1'b0, 1'b1, 1'b0},
    {1'b0, 5'd0,  1'b1, 1'b0, 1'b0},
    {1'b0, 5'd3,  1'b1, 1'b1, 1'b0},
    {1'b1, 5'd5,  1'b0, 1'b0, 1'b0},
    {1'b0, 5'd3,  1'b0, 1'b1, 1'b0},
    {1'b1, 5'd3,  1'b0, 1'b1, 1'b0},
    {1'b0, 5'd31, 1'b1, 1'b0, 1'b0},
    {1'b1, 5'd31, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [7:0] cb(input int c, input int b);
    return 8'(c * 64 + b * 3 + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_bytes(input int c, input int b0, input int b1);
    for (int b = b0; b <= b1; b++) begin
      @(negedge clk); wr_valid = 1'b1; wr_data = cb(c, b);
    end
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic poll(input bit exp, input string req);
    rx_enb_n = 1'b1; rx_addr = MY;
    @(negedge clk);
    chk(rx_clav_oe && rx_clav == exp, req, {rx_clav_oe, rx_clav}, {1'b1, exp});
    rx_addr = 5'd0;
  endtask

  task automatic read_cell(input int c, input int pause_at, input bit mid_clav);
    @(negedge clk); rx_enb_n = 1'b1; rx_addr = MY;   // select
    @(negedge clk); rx_enb_n = 1'b0;
    for (int b = 0; b < 53; b++) begin
      @(negedge clk);
      chk(rx_bus_oe && rx_data == cb(c, b) && rx_soc == (b == 0), "R2 R3 byte",
          {rx_bus_oe, rx_soc, rx_data}, {1'b1, (b == 0), cb(c, b)});
      if (b == 20)
        chk(rx_clav_oe && rx_clav == mid_clav, "R6 mid-cell", {rx_clav_oe, rx_clav}, {1'b1, mid_clav});
      if (b == 52) rx_enb_n = 1'b1;
      else if (b == pause_at) begin
        rx_enb_n = 1'b1;
        @(negedge clk);
        chk(!rx_bus_oe && rx_data == 8'h00, "R8 pause", {rx_bus_oe, rx_data}, 9'h0);
        rx_enb_n = 1'b0;
      end
    end
    rx_addr = 5'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = 8'h00; rx_enb_n = 1'b1; rx_addr = 5'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(wr_ready, "R1 wr_ready", wr_ready, 1);
    chk(!rx_bus_oe && !rx_clav_oe, "R1 enables", {rx_bus_oe, rx_clav_oe}, 0);
    chk(rx_data == 0 && !rx_soc && !rx_clav, "R1 outputs", {rx_soc, rx_clav, rx_data}, 0);

    // vector walk: R4 R5 R7 R11 with no cell stored
    foreach (VEC[i]) begin
      rx_enb_n = VEC[i][8]; rx_addr = VEC[i][7:3];
      @(negedge clk);
      chk({rx_bus_oe, rx_clav_oe, rx_clav} == VEC[i][2:0] && rx_data == 0 && !rx_soc,
          "R4 R5 R7 R11 vector", {rx_bus_oe, rx_clav_oe, rx_clav, rx_soc, rx_data},
          {VEC[i][2:0], 9'h0});
    end
    rx_enb_n = 1'b1; rx_addr = 5'd0;

    // R9: cell eligible only after its last byte
    push_bytes(0, 0, 51);
    poll(1'b0, "R9 partial cell");
    push_bytes(0, 52, 52);
    poll(1'b1, "R9 R6 full cell");

    // single cell with a pause: R8, R6 mid-transfer with none waiting
    read_cell(0, 10, 1'b0);
    poll(1'b0, "R6 after drain");
    chk(wr_ready, "R10 ready after drain", wr_ready, 1);

    // fill all slots: R10 back-pressure and ignored writes
    push_bytes(1, 0, 52);
    push_bytes(2, 0, 52);
    @(negedge clk);
    chk(!wr_ready, "R10 full", wr_ready, 0);
    wr_valid = 1'b1; wr_data = 8'hEE;
    repeat (3) begin
      @(negedge clk);
      chk(!wr_ready, "R10 held off", wr_ready, 0);
    end
    wr_valid = 1'b0;
    read_cell(1, 99, 1'b1);
    chk(wr_ready, "R10 slot freed", wr_ready, 1);
    poll(1'b1, "R6 second cell waiting");
    read_cell(2, 0, 1'b0);   // contents intact: ignored writes left no trace
    poll(1'b0, "R6 empty again");

    // R11: selected but empty
    @(negedge clk); rx_enb_n = 1'b1; rx_addr = MY;
    @(negedge clk); rx_enb_n = 1'b0;
    @(negedge clk);
    chk(rx_bus_oe && rx_data == 0 && !rx_soc, "R11 empty read", {rx_bus_oe, rx_soc, rx_data}, 10'h200);
    rx_enb_n = 1'b1;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule